// File: doc/BRIEF.md
# Periodic Tick Down-Counter

A 24-bit down-counter on a small word-addressed register bus. It provides a periodic event to a processor. Software loads a reload value and sets the enable bit. From then on the counter decrements once on every cycle in which the external `tick` input is high. When the count steps from one to zero, the block sets a sticky count flag in its control/status word. If interrupts are enabled, it also pulses `irq` for one cycle.

The counter does not reload at once. Zero is a real state that lasts one full tick. The tick after that loads the reload value. The same rule applies when counting starts: enabling the timer, or writing the current-value register, forces the count to zero. The reload therefore arrives on the next tick and not in the same cycle. The period is thus reload+1 ticks, and a reload value of zero parks the counter at zero.

Top module: `tick_timer`

## Requirements
- R1: After reset, all three registers read as zero and `irq` is low.
- R2: While enabled, a cycle with `tick` high and a nonzero count decrements the count by one. With `tick` low, or with enable (control bit 0) clear, the count holds.
- R3: While enabled, a `tick` with the count at zero loads the reload value. The counter therefore spends exactly one tick at zero before each reload.
- R4: Any write to the current-value register (offset 0x8) clears the count to zero, whatever the write data. The write also cancels any one-to-zero step in that cycle. The next enabled tick loads the reload value.
- R5: A control write that sets enable while it was clear zeroes the count, so the first tick after enabling loads the reload value.
- R6: The count flag (control bit 16, read-only) is set by every one-to-zero step. A read of the control register (offset 0x0) clears it, and so does a write to the current-value register. When a step coincides with a clearing read, the flag stays set.
- R7: When interrupt-enable (control bit 1) is set, `irq` is high for exactly the one cycle after each one-to-zero step, and never otherwise.
- R8: Bits 31..24 of the reload (offset 0x4) and current-value registers always read as zero. Write data in those bits is discarded.
- R9: With a reload value of zero, the count stays at zero on every tick and no flag or interrupt events occur.
- R10: `bus_rdata` shows the register selected by `bus_addr` in the same cycle. Offsets other than 0x0, 0x4 and 0x8 read as zero, and writes to them change nothing. Control bits other than 0 and 1 are not writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse from the time base |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects only) |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default widths: a 24-bit counter in a 32-bit data word. Writes of all-ones words therefore expose the eight discarded upper bits of both count registers. Small random reload values, including zero and one, keep the wrap, the zero dwell and back-to-back events within a few ticks of each other. This lets random bus writes and reads collide with steps, reloads and enable edges in the same cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
   localparam int unsigned EN_BIT   = 0;
   localparam int unsigned IE_BIT   = 1;
   localparam int unsigned FLAG_BIT = 16;

   localparam int unsigned OFS_CTRL   = 'h0;
   localparam int unsigned OFS_RELOAD = 'h4;
   localparam int unsigned OFS_COUNT  = 'h8;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_COUNT  = 2'd2,
      SEL_NONE   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/tt_bus_decode.sv
module tt_bus_decode
   import tick_timer_pkg::*;
#(
   parameter int unsigned ADDR_W = 4
) (
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   output reg_sel_e          sel,
   output logic              wr_ctrl,
   output logic              wr_reload,
   output logic              wr_count,
   output logic              rd_ctrl
);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
   localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);

   always_comb begin
      if (bus_addr == A_CTRL)
         sel = SEL_CTRL;
      else if (bus_addr == A_RELOAD)
         sel = SEL_RELOAD;
      else if (bus_addr == A_COUNT)
         sel = SEL_COUNT;
      else
         sel = SEL_NONE;
   end

   assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
   assign wr_reload = bus_wr && (sel == SEL_RELOAD);
   assign wr_count  = bus_wr && (sel == SEL_COUNT);
   assign rd_ctrl   = bus_rd && (sel == SEL_CTRL);
endmodule

// File: rtl/tt_down_counter.sv
module tt_down_counter #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run_en,
   input  logic             zero_req,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             step_to_zero
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic advance;
   assign advance      = tick && run_en;
   assign step_to_zero = advance && !zero_req && (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (zero_req)
         count <= '0;
      else if (advance)
         count <= (count == '0) ? reload : count - ONE;
   end
endmodule

// File: rtl/tt_event.sv
module tt_event (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic clear,
   input  logic irq_en,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         irq  <= 1'b0;
      end else begin
         if (step)
            flag <= 1'b1;
         else if (clear)
            flag <= 1'b0;
         irq <= step && irq_en;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned PAD_W = DATA_W - CNT_W;

   if (DATA_W <= FLAG_BIT) begin : g_bad_data_w
      $error("DATA_W must exceed the flag bit position");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("ADDR_W must cover the three register offsets");
   end

   reg_sel_e         sel;
   logic             wr_ctrl, wr_reload, wr_count, rd_ctrl;
   logic             en_q, ie_q, flag_q;
   logic [CNT_W-1:0] rel_q, cnt_q;
   logic             en_start, step;
   logic [DATA_W-1:0] ctrl_word, rel_word, cnt_word;
   logic             unused_wdata;

   assign unused_wdata = ^bus_wdata;

   tt_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .sel       (sel),
      .wr_ctrl   (wr_ctrl),
      .wr_reload (wr_reload),
      .wr_count  (wr_count),
      .rd_ctrl   (rd_ctrl)
   );

   assign en_start = wr_ctrl && bus_wdata[EN_BIT] && !en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ie_q  <= 1'b0;
         rel_q <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q <= bus_wdata[EN_BIT];
            ie_q <= bus_wdata[IE_BIT];
         end
         if (wr_reload)
            rel_q <= bus_wdata[CNT_W-1:0];
      end
   end

   tt_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .run_en       (en_q),
      .zero_req     (wr_count || en_start),
      .reload       (rel_q),
      .count        (cnt_q),
      .step_to_zero (step)
   );

   tt_event u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step),
      .clear  (rd_ctrl || wr_count),
      .irq_en (ie_q),
      .flag   (flag_q),
      .irq    (irq)
   );

   always_comb begin
      ctrl_word           = '0;
      ctrl_word[EN_BIT]   = en_q;
      ctrl_word[IE_BIT]   = ie_q;
      ctrl_word[FLAG_BIT] = flag_q;
   end

   if (PAD_W == 0) begin : g_full
      assign rel_word = rel_q;
      assign cnt_word = cnt_q;
   end else begin : g_pad
      assign rel_word = {{PAD_W{1'b0}}, rel_q};
      assign cnt_word = {{PAD_W{1'b0}}, cnt_q};
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL:   bus_rdata = ctrl_word;
         SEL_RELOAD: bus_rdata = rel_word;
         SEL_COUNT:  bus_rdata = cnt_word;
         default:    bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  rel_q,
   input logic              en_q,
   input logic              ie_q,
   input logic              flag_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic cnt_wr, any_wr;
   assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(8));
   assign any_wr = bus_wr;

   p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick && cnt_q > ONE && !any_wr) |=> cnt_q == CNT_W'($past(cnt_q) - ONE));

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !any_wr) |=> $stable(cnt_q));

   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick && cnt_q == '0 && !any_wr) |=> cnt_q == $past(rel_q));

   p_cvr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == '0) && !flag_q);

   p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag_q);

   p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt_q == '0) && $past(ie_q) && $past(cnt_q) == ONE);

   p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(8)) |-> (bus_rdata >> CNT_W) == '0);

   p_zero_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_q == '0 && cnt_q == '0 && !any_wr) |=> cnt_q == '0);
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .cnt_q     (cnt_q),
   .rel_q     (rel_q),
   .en_q      (en_q),
   .ie_q      (ie_q),
   .flag_q    (flag_q)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state derived from the requirements
   logic [23:0] m_cnt, m_rel;
   logic        m_en, m_ie, m_flag, m_irq;

   always #2.5 clk = ~clk;

   tick_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [31:0] model_read(input logic [3:0] a);
      case (a)
         4'h0:    return {15'b0, m_flag, 14'b0, m_ie, m_en};
         4'h4:    return {8'b0, m_rel};
         4'h8:    return {8'b0, m_cnt};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                      input logic [31:0] d, input logic t, input string req);
      logic ev, cw;
      logic [23:0] n_cnt;
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; tick = t;
      #1;
      check(req, bus_rdata, model_read(a));
      cw = w && a == 4'h8;
      ev = t && m_en && m_cnt == 24'd1 && !cw;
      n_cnt = m_cnt;
      if (cw || (w && a == 4'h0 && d[0] && !m_en)) n_cnt = '0;
      else if (t && m_en) n_cnt = (m_cnt == '0) ? m_rel : m_cnt - 24'd1;
      @(posedge clk);
      #1;
      m_irq = ev && m_ie;
      if (ev) m_flag = 1'b1;
      else if (cw || (r && a == 4'h0)) m_flag = 1'b0;
      m_cnt = n_cnt;
      if (w && a == 4'h4) m_rel = d[23:0];
      if (w && a == 4'h0) begin m_en = d[0]; m_ie = d[1]; end
      check("R7 irq", {31'b0, irq}, {31'b0, m_irq});
   endtask

   task automatic idle(input int n, input logic t, input string req);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h8, 32'h0, t, req);
   endtask

   initial begin
      m_cnt = '0; m_rel = '0; m_en = 0; m_ie = 0; m_flag = 0; m_irq = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset values on every offset
      cyc(0, 0, 4'h0, 0, 0, "R1");
      cyc(0, 0, 4'h4, 0, 0, "R1");
      cyc(0, 0, 4'h8, 0, 0, "R1");
      check("R1 irq", {31'b0, irq}, 32'h0);
      // R10/R5: load 3 and enable with interrupts; first tick reloads
      cyc(1, 0, 4'h4, 32'h3, 0, "R10");
      cyc(1, 0, 4'h0, 32'h3, 1, "R5");
      idle(1, 1, "R5");
      idle(3, 1, "R2");              // 3 -> 2 -> 1 -> 0 with event
      idle(2, 0, "R2");              // hold at zero without tick
      cyc(0, 0, 4'h0, 0, 0, "R6");   // flag visible
      idle(1, 1, "R3");              // dwell ends, reload to 3
      cyc(0, 1, 4'h0, 0, 0, "R6");   // read clears flag
      cyc(0, 0, 4'h0, 0, 0, "R6");
      // R4: current-value write zeroes regardless of data
      cyc(1, 0, 4'h8, 32'hFFAB_CDEF, 0, "R4");
      idle(2, 1, "R4");
      idle(1, 1, "R4");              // count at 1
      cyc(1, 0, 4'h8, 32'h5, 1, "R4"); // write wins over the step
      cyc(0, 0, 4'h0, 0, 0, "R4");
      // R6: step coinciding with clearing read keeps flag
      idle(3, 1, "R6");
      cyc(0, 1, 4'h0, 0, 1, "R6");
      cyc(0, 0, 4'h0, 0, 0, "R6");
      // R8: upper bits discarded
      cyc(1, 0, 4'h4, 32'hFFFF_FFFF, 0, "R8");
      cyc(0, 0, 4'h4, 0, 0, "R8");
      cyc(1, 0, 4'h8, 32'hFFFF_FFFF, 1, "R8");
      idle(1, 1, "R8");
      // R10: unmapped offset and read-only flag bit
      cyc(1, 0, 4'hC, 32'hFFFF_FFFF, 0, "R10");
      cyc(0, 0, 4'hC, 0, 0, "R10");
      cyc(1, 0, 4'h0, 32'hFFFF_FFFF, 0, "R10");
      cyc(0, 0, 4'h0, 0, 0, "R10");
      // R9: zero reload parks the counter
      cyc(1, 0, 4'h4, 32'h0, 0, "R9");
      cyc(1, 0, 4'h8, 32'h0, 0, "R9");
      idle(8, 1, "R9");
      // R2: disabled counter holds
      cyc(1, 0, 4'h4, 32'h9, 0, "R2");
      idle(3, 1, "R2");
      cyc(1, 0, 4'h0, 32'h0, 0, "R2");
      idle(4, 1, "R2");
      // constrained random mix
      void'($urandom(32'd20240611));
      for (int i = 0; i < 3000; i++) begin
         int unsigned k = $urandom_range(0, 99);
         logic [3:0] a = 4'($urandom_range(0, 3) * 4);
         logic [31:0] d;
         if (a == 4'h4) d = {$urandom_range(0, 255), 24'h0} | 32'($urandom_range(0, 6));
         else d = $urandom;
         if (a == 4'h0 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
         cyc(k < 6, k >= 6 && k < 16, a, d, $urandom_range(0, 1) == 1, "R2");
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule